// File: doc/BRIEF.md
# Switch-Driven Board Self-Test Logic

This block gives a small FPGA board a quick way to show that its clock, switches, LED bar and seven-segment digit all work. Four slide switches feed combinational lamp logic: each of the three low switches lights one lamp when it is on and a partner lamp when it is off. A further lamp lights only when the two top switches are both on. One lamp blinks from a free-running clock divider, which shows that the oscillator is running.

The same four switches select one hexadecimal digit on a common-anode seven-segment display. The segment drive is active low. The glyph decoder is a separate combinational module, so other designs can reuse it. With the default divider width and a 40 MHz clock, the blink runs at about 2.38 Hz.

Top module: `board_selftest`

## Requirements
- R1: For each k in 0..2, lamp_o[2k] equals sw_i[k]. A lamp is lit at 1.
- R2: For each k in 0..2, lamp_o[2k+1] equals the complement of sw_i[k].
- R3: lamp_o[6] is 1 exactly when sw_i[3] and sw_i[2] are both 1.
- R4: lamp_o[7] is the top bit of a DIV_WIDTH-bit counter that rises by one on every clock edge. It is therefore low for 2^(DIV_WIDTH-1) cycles and then high for 2^(DIV_WIDTH-1) cycles. The default of 24 gives about 2.38 Hz at 40 MHz.
- R5: rst_i is synchronous and active high. A clock edge with rst_i at 1 clears the counter, so lamp_o[7] reads 0 after that edge. The count restarts from 0 on the first edge after release.
- R6: seg_n_o is active low (0 lights a segment). Bit 0 drives segment A, bits 1 to 5 drive segments B to F, and bit 6 drives segment G.
- R7: The seg_n_o values for switch values 0 to F, in hex, are: 40, 79, 24, 30, 19, 12, 02, 78, 00, 10, 08, 03, 46, 21, 06, 0E. The letters are upper-case A, C, E and F and lower-case b and d. The digits 6 and 9 include their tail segments.
- R8: All sixteen glyphs differ from one another, and each one lights at least two segments.
- R9: lamp_o[6:0] and seg_n_o depend only on sw_i. They follow it with no clock delay and are unaffected by rst_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Board clock (40 MHz nominal) |
| rst_i | input | 1 | Synchronous active-high reset of the blink divider |
| sw_i | input | 4 | Slide switch levels, 1 = on |
| lamp_o | output | 8 | LED bar drive, 1 = lit |
| seg_n_o | output | 7 | Seven-segment cathode drive, 0 = lit, bit 0 = A ... bit 6 = G |

## Verification
The bench builds the block with DIV_WIDTH set to 4, so the blink lamp changes level every 8 cycles instead of every several million. With that width, full low and high phases, the wrap of the counter and a reset applied while the lamp is high all fit into a few dozen cycles. The switch lamps and glyphs do not depend on the divider width, so all sixteen switch values are checked exactly as they behave at the default width.

// File: rtl/boardtest_pkg.sv
package boardtest_pkg;

  localparam int SW_W   = 4;
  localparam int SEG_W  = 7;
  localparam int LAMP_W = 8;
  localparam int PAIRS  = 3;

  // Lit-segment pattern (1 = lit), bit 0 = A ... bit 6 = G.
  function automatic logic [SEG_W-1:0] glyph_lit(input logic [SW_W-1:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'h0: p = 7'b011_1111;
      4'h1: p = 7'b000_0110;
      4'h2: p = 7'b101_1011;
      4'h3: p = 7'b100_1111;
      4'h4: p = 7'b110_0110;
      4'h5: p = 7'b110_1101;
      4'h6: p = 7'b111_1101;
      4'h7: p = 7'b000_0111;
      4'h8: p = 7'b111_1111;
      4'h9: p = 7'b110_1111;
      4'hA: p = 7'b111_0111;
      4'hB: p = 7'b111_1100;
      4'hC: p = 7'b011_1001;
      4'hD: p = 7'b101_1110;
      4'hE: p = 7'b111_1001;
      default: p = 7'b111_0001;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hex_glyph_decoder.sv
module hex_glyph_decoder
  import boardtest_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [SW_W-1:0]  value_i,
  output logic [SEG_W-1:0] seg_o
);

  logic [SEG_W-1:0] lit;

  always_comb lit = glyph_lit(value_i);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg_o = ~lit;
    end else begin : g_high
      assign seg_o = lit;
    end
  endgenerate

endmodule

// File: rtl/switch_lamp_map.sv
module switch_lamp_map
  import boardtest_pkg::*;
#(
  parameter int NPAIR = PAIRS
) (
  input  logic [SW_W-1:0]    sw_i,
  output logic [2*NPAIR:0]   lamp_o
);

  // Each low switch drives a true lamp and a complement lamp.
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign lamp_o[2*k]   = sw_i[k];
    assign lamp_o[2*k+1] = ~sw_i[k];
  end

  // The lamp above the pairs needs both of the top two switches on.
  assign lamp_o[2*NPAIR] = sw_i[SW_W-1] & sw_i[SW_W-2];

endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
  parameter int WIDTH = 24
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic msb_o,
  output logic flip_o
);

  localparam int LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign msb_o  = cnt_q[WIDTH-1];
  // High in the cycle before the top bit changes.
  assign flip_o = &cnt_q[LOW_W-1:0];

endmodule

// File: rtl/board_selftest.sv
module board_selftest
  import boardtest_pkg::*;
#(
  parameter int DIV_WIDTH = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [SW_W-1:0]   sw_i,
  output logic [LAMP_W-1:0] lamp_o,
  output logic [SEG_W-1:0]  seg_n_o
);

  localparam int SW_LAMPS = 2*PAIRS + 1;

  logic [SW_LAMPS-1:0] sw_lamps;
  logic                blink;
  logic                div_flip;

  switch_lamp_map #(.NPAIR(PAIRS)) u_map (
    .sw_i   (sw_i),
    .lamp_o (sw_lamps)
  );

  blink_divider #(.WIDTH(DIV_WIDTH)) u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .msb_o  (blink),
    .flip_o (div_flip)
  );

  hex_glyph_decoder #(.ACTIVE_LOW(1'b1)) u_glyph (
    .value_i (sw_i),
    .seg_o   (seg_n_o)
  );

  assign lamp_o = {blink, sw_lamps};

endmodule

// File: rtl/board_selftest_chk.sv
module board_selftest_chk
  import boardtest_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SW_W-1:0]   sw,
  input logic [LAMP_W-1:0] lamp,
  input logic [SEG_W-1:0]  seg_n,
  input logic              flip
);

  assert_true_lamps_R1: assert property (@(posedge clk) disable iff (rst)
    lamp[0] == sw[0] && lamp[2] == sw[1] && lamp[4] == sw[2]);

  assert_pair_opposite_R2: assert property (@(posedge clk) disable iff (rst)
    lamp[0] != lamp[1] && lamp[2] != lamp[3] && lamp[4] != lamp[5]);

  assert_and_lamp_R3: assert property (@(posedge clk) disable iff (rst)
    lamp[6] |-> (sw[3] && sw[2]));

  assert_blink_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    flip |=> lamp[7] != $past(lamp[7]));

  assert_blink_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(lamp[7]));

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> !lamp[7]);

  assert_glyph_lit_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(~seg_n) >= 2);

endmodule

bind board_selftest board_selftest_chk u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .sw    (sw_i),
  .lamp  (lamp_o),
  .seg_n (seg_n_o),
  .flip  (div_flip)
);

// File: tb/board_selftest_tb.sv
module board_selftest_tb;

  localparam int DW = 4;
  localparam int HALF = 1 << (DW - 1);
  localparam logic [6:0] SEG_TBL [16] = '{
    7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
    7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sw  = 4'h0;
  logic [7:0] lamp;
  logic [6:0] seg_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [6:0] seen [16];

  always #2.5 clk = ~clk;

  board_selftest #(.DIV_WIDTH(DW)) u_dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .sw_i    (sw),
    .lamp_o  (lamp),
    .seg_n_o (seg_n)
  );

  function automatic logic [6:0] want_lamps(input logic [3:0] v);
    logic [6:0] e;
    e[6] = (v[3:2] == 2'b11);
    for (int k = 0; k < 3; k++) begin
      e[2*k]   = v[k];
      e[2*k+1] = (v[k] == 1'b0);
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state and lamps/glyph during reset (R5, R9)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 blink low in reset", {7'b0, lamp[7]}, 8'h00);
    sw = 4'hD;
    #1;
    chk("R9 lamps under reset", {1'b0, lamp[6:0]}, {1'b0, want_lamps(4'hD)});
    chk("R9 glyph under reset", {1'b0, seg_n}, {1'b0, SEG_TBL[13]});
    rst = 1'b0;

    // Table walk: R1 R2 R3 R6 R7
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sw = 4'(i);
      #1;
      chk("R1/R2/R3 lamps", {1'b0, lamp[6:0]}, {1'b0, want_lamps(4'(i))});
      chk("R6/R7 glyph", {1'b0, seg_n}, {1'b0, SEG_TBL[i]});
      seen[i] = seg_n;
    end

    // R8 distinct glyphs, at least two segments lit
    begin
      int bad = 0;
      for (int a = 0; a < 16; a++) begin
        if ($countones(~seen[a]) < 2) bad++;
        for (int b = a + 1; b < 16; b++)
          if (seen[a] == seen[b]) bad++;
      end
      chk("R8 distinct glyphs", 8'(bad), 8'h00);
    end

    // R4 blink timing from a fresh reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R5 count restart", {7'b0, lamp[7]}, 8'h00);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      chk("R4 blink phase", {7'b0, lamp[7]}, {7'b0, 1'(((k % (2*HALF)) >= HALF))});
    end

    // R5 reset while the blink lamp is high
    chk("R5 pre-reset high", {7'b0, lamp[7]}, 8'h01);
    rst = 1'b1;
    @(negedge clk);
    chk("R5 reset clears blink", {7'b0, lamp[7]}, 8'h00);
    @(negedge clk);
    chk("R5 held in reset", {7'b0, lamp[7]}, 8'h00);
    rst = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R4 high after half period", {7'b0, lamp[7]}, 8'h01);

    // R9 switches change with no clock delay
    @(negedge clk);
    sw = 4'hB;
    #0.5;
    chk("R9 immediate glyph", {1'b0, seg_n}, {1'b0, SEG_TBL[11]});
    chk("R9 immediate lamps", {1'b0, lamp[6:0]}, {1'b0, want_lamps(4'hB)});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule